// File: doc/BRIEF.md
# Configurable Bidirectional Bus Transceiver

An eight-bit transceiver that joins a split A side (a dedicated input bus and a dedicated output bus) to a shared open-drain B bus. Each direction passes through its own storage element. A two-bit mode select sets that element to pass-through, transparent latch or edge-captured register. A per-direction strobe serves as the capture clock in register mode and as the latch enable in latch mode. Data is inverted between input and output in every mode and in both directions.

The open-drain B side is modelled as a per-bit pull-low request (`b_pull`). The line value comes back on `b_line` as the resolved bus: a line that nobody pulls low reads high. The B-to-A element therefore also sees what this block drives itself. A loopback select replaces the B-side receive data with the A-to-B element's value, taken before its inversion. The B side drives only under one combination of its two enables. The A output carries a drive-enable flag that stands for its high-impedance state.

The block runs on one system clock. The strobes are sampled on that clock, so a register capture is the first cycle a strobe is seen high. A synchronous active-high reset clears both stored values.

Top module: `bidir_xcvr`

## Requirements
- R1: Mode select per direction: bit 1 high selects pass-through whatever bit 0 is. Bits 1:0 = 01 select transparent latch. Bits 1:0 = 00 select register. In pass-through the element value equals its input and the strobe has no effect.
- R2: In register mode the element captures its input on the clock edge where the strobe is sampled high after being sampled low in the previous cycle. It holds that value at every other edge, including while the strobe stays high.
- R3: In latch mode the element value follows its input while the strobe is high. Once the strobe goes low, it holds the input last seen at a clock edge with the strobe high.
- R4: Inversion: `b_pull[i]` is 1 (line pulled low) exactly when the A-to-B element bit i is 1 and the B side is enabled. `a_data` is the bitwise complement of the B-to-A element value.
- R5: The B side is enabled only when `b_en_p` = 1 and `b_en_n` = 0. In the other three combinations `b_pull` is all zero, so every line reads high.
- R6: `a_drive` equals `a_oe`. A value of 0 stands for a high-impedance A output.
- R7: With `loop_sel` = 1 the B-to-A element input is the uninverted A-to-B element value, and `b_line` has no effect on `a_data`.
- R8: Capture and hold continue while the outputs are disabled or released. A value captured with the B side released appears once the B side is enabled.
- R9: With `loop_sel` = 0 the B-to-A input is `b_line`, the resolved bus, so a value this block drives is received back by its own B-to-A path.
- R10: A clock edge with `rst` high clears both stored values to zero. After it, register mode gives `b_pull` = 00 and `a_data` = FF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_ab | input | 2 | A-to-B element mode select |
| mode_ba | input | 2 | B-to-A element mode select |
| strobe_ab | input | 1 | A-to-B capture strobe / latch enable |
| strobe_ba | input | 1 | B-to-A capture strobe / latch enable |
| loop_sel | input | 1 | Loopback select |
| b_en_p | input | 1 | B enable, active high |
| b_en_n | input | 1 | B enable, active low |
| a_oe | input | 1 | A output enable |
| a_in | input | W | A-side input bus |
| b_line | input | W | Resolved B bus level |
| b_pull | output | W | Open-drain pull-low request per B line |
| a_data | output | W | A-side output data |
| a_drive | output | 1 | A output driven (0 = high impedance) |

## Verification
A vector table covers pass-through under all four B-enable combinations. Alternating byte patterns are used so that a missing inversion or a swapped enable polarity shows up on every bit. Register vectors hold the strobe high over several edges with changing data, which separates edge capture from level capture. Latch vectors drop the strobe while the data changes, which shows whether the hold keeps the last transparent value. Directed sequences capture data while the B side is released, toggle the external bus under loopback to show it has no effect, receive the block's own driven value, and apply reset after nonzero values are stored.

// File: rtl/bidir_xcvr_pkg.sv
package bidir_xcvr_pkg;

    parameter int DATA_W = 8;

    typedef enum logic [1:0] {
        ELEM_REG   = 2'd0,
        ELEM_LATCH = 2'd1,
        ELEM_PASS  = 2'd2
    } elem_mode_e;

    typedef struct packed {
        logic en_p;
        logic en_n;
    } bside_en_t;

    function automatic elem_mode_e decode_mode(input logic [1:0] sel);
        if (sel[1])
            return ELEM_PASS;
        else if (sel[0])
            return ELEM_LATCH;
        else
            return ELEM_REG;
    endfunction

    function automatic logic bside_active(input bside_en_t en);
        return en.en_p & ~en.en_n;
    endfunction

endpackage

// File: rtl/xcvr_elem.sv
module xcvr_elem
    import bidir_xcvr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  elem_mode_e       mode,
    input  logic             strobe,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout
);

    logic [W-1:0] store_q;
    logic         strobe_q;
    logic         capture;

    always_comb begin
        case (mode)
            ELEM_REG:   capture = strobe & ~strobe_q;
            ELEM_LATCH: capture = strobe;
            default:    capture = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q  <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= strobe;
            if (capture)
                store_q <= din;
        end
    end

    always_comb begin
        case (mode)
            ELEM_PASS:  dout = din;
            ELEM_LATCH: dout = strobe ? din : store_q;
            default:    dout = store_q;
        endcase
    end

endmodule

// File: rtl/xcvr_bport.sv
module xcvr_bport
    import bidir_xcvr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  bside_en_t        en,
    input  logic [W-1:0]     elem_val,
    output logic [W-1:0]     pull
);

    logic active;

    assign active = bside_active(en);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign pull[i] = active & elem_val[i];
    end

endmodule

// File: rtl/xcvr_rxmux.sv
module xcvr_rxmux
    import bidir_xcvr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic             loop_sel,
    input  logic [W-1:0]     tx_val,
    input  logic [W-1:0]     line,
    output logic [W-1:0]     rx_src
);

    assign rx_src = loop_sel ? tx_val : line;

endmodule

// File: rtl/bidir_xcvr.sv
module bidir_xcvr
    import bidir_xcvr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_ab,
    input  logic [1:0]       mode_ba,
    input  logic             strobe_ab,
    input  logic             strobe_ba,
    input  logic             loop_sel,
    input  logic             b_en_p,
    input  logic             b_en_n,
    input  logic             a_oe,
    input  logic [W-1:0]     a_in,
    input  logic [W-1:0]     b_line,
    output logic [W-1:0]     b_pull,
    output logic [W-1:0]     a_data,
    output logic             a_drive
);

    elem_mode_e   m_ab;
    elem_mode_e   m_ba;
    bside_en_t    ben;
    logic [W-1:0] v_ab;
    logic [W-1:0] v_ba;
    logic [W-1:0] src_ba;

    assign m_ab = decode_mode(mode_ab);
    assign m_ba = decode_mode(mode_ba);
    assign ben  = '{en_p: b_en_p, en_n: b_en_n};

    xcvr_elem #(.W(W)) u_elem_ab (
        .clk    (clk),
        .rst    (rst),
        .mode   (m_ab),
        .strobe (strobe_ab),
        .din    (a_in),
        .dout   (v_ab)
    );

    xcvr_bport #(.W(W)) u_bport (
        .en       (ben),
        .elem_val (v_ab),
        .pull     (b_pull)
    );

    xcvr_rxmux #(.W(W)) u_rxmux (
        .loop_sel (loop_sel),
        .tx_val   (v_ab),
        .line     (b_line),
        .rx_src   (src_ba)
    );

    xcvr_elem #(.W(W)) u_elem_ba (
        .clk    (clk),
        .rst    (rst),
        .mode   (m_ba),
        .strobe (strobe_ba),
        .din    (src_ba),
        .dout   (v_ba)
    );

    assign a_data  = ~v_ba;
    assign a_drive = a_oe;

endmodule

// File: rtl/bidir_xcvr_chk.sv
module bidir_xcvr_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   mode_ab,
    input logic [1:0]   mode_ba,
    input logic         strobe_ab,
    input logic         loop_sel,
    input logic         b_en_p,
    input logic         b_en_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_pull,
    input logic [W-1:0] a_data
);

    logic b_on;
    assign b_on = b_en_p & ~b_en_n;

    // R2: no strobe in register mode, so the driven value is unchanged next cycle
    a_r2_reg_hold: assert property (@(posedge clk) disable iff (rst)
        (mode_ab == 2'b00 && !strobe_ab && b_on)
        |=> (mode_ab != 2'b00 || !b_on || $stable(b_pull)));

    // R3: latch open means B follows A
    a_r3_latch_open: assert property (@(posedge clk) disable iff (rst)
        (mode_ab == 2'b01 && strobe_ab && b_on) |-> (b_pull == a_in));

    // R4: pass-through pulls low exactly the ones of the A input
    a_r4_pass_invert: assert property (@(posedge clk) disable iff (rst)
        (mode_ab[1] && b_on) |-> (b_pull == a_in));

    // R5: any other enable combination releases every line
    a_r5_b_release: assert property (@(posedge clk) disable iff (rst)
        !b_on |-> (b_pull == '0));

    // R7: loopback through two pass elements returns the A input inverted
    a_r7_loop_path: assert property (@(posedge clk) disable iff (rst)
        (loop_sel && mode_ab[1] && mode_ba[1]) |-> (a_data == ~a_in));

endmodule

bind bidir_xcvr bidir_xcvr_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_ab   (mode_ab),
    .mode_ba   (mode_ba),
    .strobe_ab (strobe_ab),
    .loop_sel  (loop_sel),
    .b_en_p    (b_en_p),
    .b_en_n    (b_en_n),
    .a_in      (a_in),
    .b_pull    (b_pull),
    .a_data    (a_data)
);

// File: tb/bidir_xcvr_tb.sv
`timescale 1ns/1ps
module bidir_xcvr_tb;

    localparam int W = 8;
    localparam int NV = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   mode_ab = 2'b00, mode_ba = 2'b00;
    logic         strobe_ab = 1'b0, strobe_ba = 1'b0;
    logic         loop_sel = 1'b0, b_en_p = 1'b0, b_en_n = 1'b0, a_oe = 1'b0;
    logic [W-1:0] a_in = '0, ext_pull = '0;
    logic [W-1:0] b_line, b_pull, a_data;
    logic         a_drive;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    logic [W-1:0] s_ab = '0, s_ba = '0;
    logic         p_ab = 1'b0, p_ba = 1'b0;

    always #2 clk = ~clk;

    assign b_line = ~(b_pull | ext_pull);

    bidir_xcvr #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .mode_ab(mode_ab), .mode_ba(mode_ba),
        .strobe_ab(strobe_ab), .strobe_ba(strobe_ba), .loop_sel(loop_sel),
        .b_en_p(b_en_p), .b_en_n(b_en_n), .a_oe(a_oe), .a_in(a_in),
        .b_line(b_line), .b_pull(b_pull), .a_data(a_data), .a_drive(a_drive)
    );

    // fields: mab[25:24] mba[23:22] sab[21] sba[20] loop[19] bp[18] bn[17] aoe[16] ain[15:8] ext[7:0]
    localparam logic [25:0] VECS [NV] = '{
        {2'b10, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hA5, 8'h00},
        {2'b11, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h3C, 8'hC0},
        {2'b10, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h00},
        {2'b10, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0F, 8'h00},
        {2'b10, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hF0, 8'h81},
        {2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h5A, 8'h00},
        {2'b00, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h5A, 8'h00},
        {2'b00, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h11, 8'h00},
        {2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h22, 8'h00},
        {2'b01, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h81, 8'h00},
        {2'b01, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h42, 8'h00},
        {2'b01, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h00},
        {2'b10, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h0F},
        {2'b10, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'hF0},
        {2'b10, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h96, 8'h00},
        {2'b10, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h69, 8'hFF}
    };

    function automatic string tag_of(input int i);
        if (i < 5)       return "R1";
        else if (i < 9)  return "R2";
        else if (i < 12) return "R3";
        else if (i < 14) return "R2 rx";
        else             return "R3 R7 rx";
    endfunction

    function automatic logic [W-1:0] m_val(input logic [1:0] m, input logic s,
                                           input logic [W-1:0] d, input logic [W-1:0] st);
        if (m[1])      return d;
        else if (m[0]) return s ? d : st;
        else           return st;
    endfunction

    function automatic logic [W-1:0] m_next(input logic [1:0] m, input logic s, input logic p,
                                            input logic [W-1:0] d, input logic [W-1:0] st);
        if (m[1])      return st;
        else if (m[0]) return s ? d : st;
        else           return (s && !p) ? d : st;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [25:0] v, input string tag);
        logic [W-1:0] vab, pull, line, src, vba;
        logic on;
        @(negedge clk);
        mode_ab = v[25:24]; mode_ba = v[23:22];
        strobe_ab = v[21]; strobe_ba = v[20]; loop_sel = v[19];
        b_en_p = v[18]; b_en_n = v[17]; a_oe = v[16];
        a_in = v[15:8]; ext_pull = v[7:0];
        on = b_en_p & ~b_en_n;
        // values seen at the coming edge
        vab  = m_val(mode_ab, strobe_ab, a_in, s_ab);
        pull = on ? vab : '0;
        line = ~(pull | ext_pull);
        src  = loop_sel ? vab : line;
        s_ba = m_next(mode_ba, strobe_ba, p_ba, src, s_ba);
        s_ab = m_next(mode_ab, strobe_ab, p_ab, a_in, s_ab);
        p_ab = strobe_ab; p_ba = strobe_ba;
        // values after the edge
        vab  = m_val(mode_ab, strobe_ab, a_in, s_ab);
        pull = on ? vab : '0;
        line = ~(pull | ext_pull);
        src  = loop_sel ? vab : line;
        vba  = m_val(mode_ba, strobe_ba, src, s_ba);
        @(posedge clk);
        #1;
        check({tag, " R5 b_pull"}, b_pull, pull);
        check({tag, " R4 a_data"}, a_data, ~vba);
        check({tag, " R6 a_drive"}, {7'b0, a_drive}, {7'b0, a_oe});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: state right after initial reset, register mode both ways
        b_en_p = 1'b1; b_en_n = 1'b0; a_in = 8'hFF;
        #0.5;
        check("R10 reset b_pull", b_pull, 8'h00);
        check("R10 reset a_data", a_data, 8'hFF);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++)
            apply(VECS[i], tag_of(i));

        // R8: capture while B released, appears once enabled
        apply({2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h77, 8'h00}, "R8");
        apply({2'b00, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h77, 8'h00}, "R8");
        apply({2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00}, "R8");
        checks++;
        if (b_pull !== 8'h77) begin
            errors++;
            $display("FAIL R8 held b_pull actual %h expected %h", b_pull, 8'h77);
        end
        // R8: B-to-A latch keeps capturing while A output disabled
        apply({2'b10, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h3E}, "R8");
        apply({2'b10, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00}, "R8");
        checks++;
        if (a_data !== 8'h3E) begin
            errors++;
            $display("FAIL R8 held a_data actual %h expected %h", a_data, 8'h3E);
        end

        // R7: external bus toggles under loopback, a_data unchanged
        apply({2'b10, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'hC3, 8'h00}, "R7");
        apply({2'b10, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'hC3, 8'hFF}, "R7");
        checks++;
        if (a_data !== 8'h3C) begin
            errors++;
            $display("FAIL R7 loop a_data actual %h expected %h", a_data, 8'h3C);
        end

        // R9: own driven value received back
        apply({2'b10, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h6B, 8'h00}, "R9");
        checks++;
        if (a_data !== 8'h6B) begin
            errors++;
            $display("FAIL R9 self receive actual %h expected %h", a_data, 8'h6B);
        end

        // R10: reset after nonzero values were stored
        apply({2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hAA, 8'h55}, "R10 pre");
        @(negedge clk);
        rst = 1'b1; strobe_ab = 1'b0; strobe_ba = 1'b0;
        @(posedge clk);
        #1;
        check("R10 rst b_pull", b_pull, 8'h00);
        check("R10 rst a_data", a_data, 8'hFF);
        @(negedge clk);
        rst = 1'b0;
        s_ab = '0; s_ba = '0; p_ab = 1'b0; p_ba = 1'b0;
        apply({2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hAA, 8'h00}, "R10 post");

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule